// File: doc/BRIEF.md
# Request-Merging Read-Modify-Write Line Cache

This block sits between an update pipeline and a slow line-addressed memory. Each update request names a memory line and carries a value that is added into that line (modulo 2^DW). A small fully associative set of entries keeps the lines in use. An update to a resident line is applied in place with no memory traffic. An update to an absent line claims an entry and issues exactly one memory read. Any further update to that line while the read is outstanding is accumulated into the same entry instead of starting a second access. A modified line goes back to memory only when its entry is evicted or when a flush is requested.

Because one address can never occupy two entries, a stream that is heavily skewed toward a few lines costs one read and at most one write per residency of each line. The read-after-write hazard is removed: an update never reads a stale copy from memory while a newer one is in flight. Each completion reports the line, its new value and how many accepted requests the completion covers.

Top module: `merge_rmw_cache`

## Requirements
- R1: After reset `req_ready` is 1 with `req_valid` low, and `cpl_valid`, `mem_rd_valid`, `mem_wr_valid` and `flush_done` are 0.
- R2: An accepted request to a line that no entry holds drives `mem_rd_valid` with `mem_rd_addr` equal to the request address in the acceptance cycle. It is the only read for that line until the line is evicted.
- R3: An accepted request to a resident line whose read has returned causes no memory read or write. One cycle later it gives `cpl_valid` with `cpl_count` = 1 and `cpl_value` = old line value + `req_data` (mod 2^DW).
- R4: Requests accepted for a line whose read is still outstanding issue no read. One cycle after `mem_rsp_valid` for that line, a single completion reports `cpl_value` = returned data + the sum of all those updates, and `cpl_count` = the number of requests merged.
- R5: No two valid entries ever hold the same line address.
- R6: When a miss finds no free entry, the victim is the least recently accepted entry among those with no outstanding read. If the victim is dirty, it is written back (its address and current value) in the same cycle as the new read.
- R7: `req_ready` is 0 in any cycle where `mem_rsp_valid` is 1, or a flush is in progress, or a miss finds every entry waiting on a read, or a waiting line already holds 2^CW-1 merged requests.
- R8: A one-cycle `flush_req` waits until no read is outstanding. It then writes every dirty line to memory once, one per cycle, and pulses `flush_done` for one cycle. Afterwards the lines stay resident and clean, so a new update to one of them issues no read.
- R9: Memory read responses are taken in issue order. Every accepted request is covered by exactly one completion.
- R10: Line values wrap modulo 2^DW. Adding all-ones twice lowers a line by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | AW | Line address of the update |
| req_data | input | DW | Value added to the line |
| mem_rd_valid | output | 1 | Memory read issued |
| mem_rd_addr | output | AW | Line to read |
| mem_rsp_valid | input | 1 | Read data returning, in issue order |
| mem_rsp_data | input | DW | Returned line value |
| mem_wr_valid | output | 1 | Memory write issued |
| mem_wr_addr | output | AW | Line to write |
| mem_wr_data | output | DW | Line value written |
| cpl_valid | output | 1 | Completion present |
| cpl_addr | output | AW | Line of the completion |
| cpl_value | output | DW | Line value after the covered updates |
| cpl_count | output | CW | Number of requests covered |
| flush_req | input | 1 | Start write-back of all dirty lines |
| flush_done | output | 1 | One-cycle pulse when the flush is complete |

## Verification
A wrong entry state shows up at the ports within a few cycles. A duplicated or lost tag gives an extra read for a line already held, or a completion whose value misses earlier updates; both appear on the next request to that line. A wrong dirty bit or a wrong LRU age shows up when a line is evicted: the written-back address or value does not match the running sum kept by the bench. A flush exposes any dirty line that was never written, because memory is then compared with the running sums in full. Completion counts are checked one for one against queued expectations, so a dropped merge shows at the fill that should have covered it.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
   typedef enum logic [1:0] {
      FL_IDLE  = 2'd0,
      FL_DRAIN = 2'd1,
      FL_WRITE = 2'd2
   } flush_state_e;
endpackage

// File: rtl/mrc_tag_match.sv
module mrc_tag_match #(
   parameter int N  = 4,
   parameter int AW = 16,
   parameter int IW = 2
) (
   input  logic [N-1:0]         vld,
   input  logic [N-1:0][AW-1:0] tags,
   input  logic [AW-1:0]        addr,
   output logic [N-1:0]         hit_vec,
   output logic                 hit,
   output logic [IW-1:0]        hit_idx
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = vld[g] && (tags[g] == addr);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) hit_idx = hit_idx | IW'(i);
      end
   end
endmodule

// File: rtl/mrc_lru.sv
module mrc_lru #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [IW-1:0] touch_idx,
   input  logic [N-1:0]  vld,
   input  logic [N-1:0]  elig,
   output logic [IW-1:0] victim_idx,
   output logic          victim_ok
);
   logic [IW-1:0] age [N];
   logic          have_inv, have_old;
   logic [IW-1:0] inv_idx, old_idx, best;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age[i] <= IW'(i);
      end else if (touch) begin
         for (int i = 0; i < N; i++) begin
            if (IW'(i) == touch_idx)        age[i] <= '0;
            else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
         end
      end
   end

   always_comb begin
      have_inv = 1'b0;
      have_old = 1'b0;
      inv_idx  = '0;
      old_idx  = '0;
      best     = '0;
      for (int i = 0; i < N; i++) begin
         if (elig[i]) begin
            if (!vld[i]) begin
               if (!have_inv) begin
                  have_inv = 1'b1;
                  inv_idx  = IW'(i);
               end
            end else if (!have_old || age[i] > best) begin
               have_old = 1'b1;
               old_idx  = IW'(i);
               best     = age[i];
            end
         end
      end
      victim_idx = have_inv ? inv_idx : old_idx;
      victim_ok  = have_inv | have_old;
   end
endmodule

// File: rtl/mrc_idx_fifo.sv
module mrc_idx_fifo #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [IW-1:0] push_idx,
   input  logic          pop,
   output logic [IW-1:0] head_idx,
   output logic          empty
);
   logic [IW-1:0] slot [N];
   logic [IW-1:0] wp, rp;
   logic [IW:0]   cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         for (int i = 0; i < N; i++) slot[i] <= '0;
      end else begin
         if (push) begin
            slot[wp] <= push_idx;
            wp       <= wp + 1'b1;
         end
         if (pop) rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign head_idx = slot[rp];
   assign empty    = (cnt == '0);
endmodule

// File: rtl/merge_rmw_cache.sv
module merge_rmw_cache
   import mrc_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 16,
   parameter int ENTRIES = 4,
   parameter int CW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   output logic          mem_rd_valid,
   output logic [AW-1:0] mem_rd_addr,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data,
   output logic          mem_wr_valid,
   output logic [AW-1:0] mem_wr_addr,
   output logic [DW-1:0] mem_wr_data,
   output logic          cpl_valid,
   output logic [AW-1:0] cpl_addr,
   output logic [DW-1:0] cpl_value,
   output logic [CW-1:0] cpl_count,
   input  logic          flush_req,
   output logic          flush_done
);
   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

   if (ENTRIES < 2 || (1 << IW) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("CW must be at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_widths
      $error("AW and DW must be positive");
   end

   // entry state
   logic [ENTRIES-1:0]         e_vld, e_pend, e_dirty;
   logic [ENTRIES-1:0][AW-1:0] e_tag;
   logic [DW-1:0]              e_val   [ENTRIES];
   logic [DW-1:0]              e_delta [ENTRIES];
   logic [CW-1:0]              e_wcnt  [ENTRIES];

   // lookup and replacement
   logic [ENTRIES-1:0] hit_vec;
   logic               hit;
   logic [IW-1:0]      hit_idx, vic_idx, head_idx;
   logic               vic_ok, fifo_empty;
   logic               hit_rdy, hit_pnd, pnd_full, fire, fill, miss_ok;
   logic               ev_wr, fl_wr, any_dirty, flush_busy;
   logic [IW-1:0]      fl_idx;
   flush_state_e       fl_state;

   mrc_tag_match #(.N(ENTRIES), .AW(AW), .IW(IW)) u_match (
      .vld(e_vld), .tags(e_tag), .addr(req_addr),
      .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx)
   );

   mrc_lru #(.N(ENTRIES), .IW(IW)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .touch(fire), .touch_idx(hit ? hit_idx : vic_idx),
      .vld(e_vld), .elig(~e_pend),
      .victim_idx(vic_idx), .victim_ok(vic_ok)
   );

   mrc_idx_fifo #(.N(ENTRIES), .IW(IW)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(fire && !hit), .push_idx(vic_idx),
      .pop(fill), .head_idx(head_idx), .empty(fifo_empty)
   );

   // request acceptance
   assign fill       = mem_rsp_valid;
   assign flush_busy = (fl_state != FL_IDLE);
   assign hit_rdy    = hit && !e_pend[hit_idx];
   assign hit_pnd    = hit && e_pend[hit_idx];
   assign pnd_full   = (e_wcnt[hit_idx] == CNT_MAX);
   assign miss_ok    = !hit && vic_ok;
   assign req_ready  = !fill && !flush_busy &&
                       (hit_rdy || (hit_pnd && !pnd_full) || miss_ok);
   assign fire       = req_valid && req_ready;

   assign mem_rd_valid = fire && !hit;
   assign mem_rd_addr  = req_addr;

   // write-back selection
   always_comb begin
      fl_idx    = '0;
      any_dirty = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (e_dirty[i]) begin
            fl_idx    = IW'(i);
            any_dirty = 1'b1;
         end
      end
   end

   assign ev_wr        = fire && !hit && e_vld[vic_idx] && e_dirty[vic_idx];
   assign fl_wr        = (fl_state == FL_WRITE) && any_dirty;
   assign mem_wr_valid = ev_wr || fl_wr;
   assign mem_wr_addr  = fl_wr ? e_tag[fl_idx] : e_tag[vic_idx];
   assign mem_wr_data  = fl_wr ? e_val[fl_idx] : e_val[vic_idx];

   // entry update
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_vld   <= '0;
         e_pend  <= '0;
         e_dirty <= '0;
         e_tag   <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            e_val[i]   <= '0;
            e_delta[i] <= '0;
            e_wcnt[i]  <= '0;
         end
      end else begin
         if (fire) begin
            if (hit_rdy) begin
               e_val[hit_idx]   <= e_val[hit_idx] + req_data;
               e_dirty[hit_idx] <= 1'b1;
            end else if (hit_pnd) begin
               e_delta[hit_idx] <= e_delta[hit_idx] + req_data;
               e_wcnt[hit_idx]  <= e_wcnt[hit_idx] + 1'b1;
            end else begin
               e_vld[vic_idx]   <= 1'b1;
               e_pend[vic_idx]  <= 1'b1;
               e_dirty[vic_idx] <= 1'b0;
               e_tag[vic_idx]   <= req_addr;
               e_delta[vic_idx] <= req_data;
               e_wcnt[vic_idx]  <= CW'(1);
            end
         end
         if (fill) begin
            e_val[head_idx]   <= mem_rsp_data + e_delta[head_idx];
            e_pend[head_idx]  <= 1'b0;
            e_dirty[head_idx] <= 1'b1;
         end
         if (fl_wr) e_dirty[fl_idx] <= 1'b0;
      end
   end

   // flush sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_state   <= FL_IDLE;
         flush_done <= 1'b0;
      end else begin
         flush_done <= 1'b0;
         case (fl_state)
            FL_IDLE:  if (flush_req) fl_state <= FL_DRAIN;
            FL_DRAIN: if (fifo_empty) fl_state <= FL_WRITE;
            FL_WRITE: if (!any_dirty) begin
                         flush_done <= 1'b1;
                         fl_state   <= FL_IDLE;
                      end
            default:  fl_state <= FL_IDLE;
         endcase
      end
   end

   // completions
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpl_valid <= 1'b0;
         cpl_addr  <= '0;
         cpl_value <= '0;
         cpl_count <= '0;
      end else begin
         cpl_valid <= fill || (fire && hit_rdy);
         if (fill) begin
            cpl_addr  <= e_tag[head_idx];
            cpl_value <= mem_rsp_data + e_delta[head_idx];
            cpl_count <= e_wcnt[head_idx];
         end else if (fire && hit_rdy) begin
            cpl_addr  <= req_addr;
            cpl_value <= e_val[hit_idx] + req_data;
            cpl_count <= CW'(1);
         end
      end
   end
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
   parameter int N  = 4,
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [N-1:0]  hit_vec,
   input logic          hit_rdy,
   input logic          mem_rd_valid,
   input logic          mem_wr_valid,
   input logic          mem_rsp_valid,
   input logic          cpl_valid,
   input logic [CW-1:0] cpl_count,
   input logic          flush_busy,
   input logic          flush_done,
   input logic          fifo_empty
);
   // R5
   a_r5_unique_lines: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R3
   a_r3_hit_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && hit_rdy) |-> (!mem_rd_valid && !mem_wr_valid));

   a_r3_hit_cpl: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && hit_rdy) |=> (cpl_valid && cpl_count == CW'(1)));

   // R2
   a_r2_read_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (req_valid && req_ready && hit_vec == '0));

   // R7
   a_r7_fill_stall: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> !req_ready);

   a_r7_flush_stall: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |-> !req_ready);

   // R4
   a_r4_fill_cpl: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |=> (cpl_valid && cpl_count != '0));

   // R8
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |=> !flush_done);

   a_r8_done_drained: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> fifo_empty);
endmodule

bind merge_rmw_cache mrc_checker #(.N(ENTRIES), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .hit_vec(hit_vec), .hit_rdy(hit_rdy), .mem_rd_valid(mem_rd_valid),
   .mem_wr_valid(mem_wr_valid), .mem_rsp_valid(mem_rsp_valid),
   .cpl_valid(cpl_valid), .cpl_count(cpl_count), .flush_busy(flush_busy),
   .flush_done(flush_done), .fifo_empty(fifo_empty)
);

// File: tb/tb_merge_rmw_cache.sv
module tb_merge_rmw_cache;
   localparam int AW = 6, DW = 16, N = 4, CW = 3, LAT = 3;
   localparam int NA = 1 << AW;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          req_valid = 1'b0, req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          mem_rd_valid, mem_wr_valid, cpl_valid, flush_done;
   logic [AW-1:0] mem_rd_addr, mem_wr_addr, cpl_addr;
   logic [DW-1:0] mem_wr_data, cpl_value;
   logic [CW-1:0] cpl_count;
   logic          mem_rsp_valid = 1'b0, flush_req = 1'b0;
   logic [DW-1:0] mem_rsp_data = '0;

   always #4 clk = ~clk;

   merge_rmw_cache #(.AW(AW), .DW(DW), .ENTRIES(N), .CW(CW)) dut (.*);

   int unsigned vectors = 0, errors = 0, cyc = 0;
   logic [DW-1:0] mem    [NA];
   logic [DW-1:0] golden [NA];
   logic [DW-1:0] expq   [NA][$];
   int unsigned   rd_cnt [NA];
   int unsigned   max_cnt [NA];
   logic [DW-1:0] last_val [NA];
   int unsigned   tot_rd = 0, tot_wr = 0, done_seen = 0;
   logic [AW-1:0] last_wr_addr = '0;
   logic [AW-1:0] rq_addr [$];
   int unsigned   rq_due  [$];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: pushes expected prefix values on acceptance
   task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_data = d;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      golden[a] = golden[a] + d;
      expq[a].push_back(golden[a]);
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // memory model and monitor
   initial begin
      for (int i = 0; i < NA; i++) begin
         mem[i] = DW'(i * 7 + 1); golden[i] = mem[i];
         rd_cnt[i] = 0; max_cnt[i] = 0; last_val[i] = '0;
      end
      forever begin
         @(negedge clk);
         cyc++;
         mem_rsp_valid = 1'b0;
         if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem[rq_addr[0]];
            void'(rq_due.pop_front());
            void'(rq_addr.pop_front());
         end
         #2;
         if (rst_n) begin
            if (mem_rsp_valid) check(!req_ready, "R7", "ready during fill", int'(req_ready), 0);
            if (mem_rd_valid) begin
               rd_cnt[mem_rd_addr]++; tot_rd++;
               rq_addr.push_back(mem_rd_addr); rq_due.push_back(cyc + LAT);
            end
            if (mem_wr_valid) begin
               tot_wr++; last_wr_addr = mem_wr_addr;
               check(mem_wr_data == golden[mem_wr_addr], "R6", "write-back value",
                     int'(mem_wr_data), int'(golden[mem_wr_addr]));
               mem[mem_wr_addr] = mem_wr_data;
            end
            if (cpl_valid) begin
               logic [DW-1:0] e = '0;
               check(expq[cpl_addr].size() >= int'(cpl_count) && cpl_count != 0, "R9",
                     "completion count vs queued", int'(cpl_count), expq[cpl_addr].size());
               for (int k = 0; k < int'(cpl_count); k++)
                  if (expq[cpl_addr].size() > 0) e = expq[cpl_addr].pop_front();
               check(cpl_value == e, "R4", "completion value", int'(cpl_value), int'(e));
               if (int'(cpl_count) > max_cnt[cpl_addr]) max_cnt[cpl_addr] = int'(cpl_count);
               last_val[cpl_addr] = cpl_value;
            end
            if (flush_done) done_seen++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      int unsigned rd0, wr0, bad;
      logic [15:0] lfsr = 16'hACE1;
      logic [AW-1:0] la = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #3;
      // R1 reset state
      check(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
      check(!cpl_valid && !mem_rd_valid && !mem_wr_valid && !flush_done, "R1",
            "quiet outputs", int'({cpl_valid, mem_rd_valid, mem_wr_valid, flush_done}), 0);

      // R2 single miss
      send(6'd5, 16'd3); idle(8);
      check(rd_cnt[5] == 1, "R2", "reads of line 5", rd_cnt[5], 1);

      // R4 back-to-back merge on a pending line
      for (int i = 0; i < 6; i++) send(6'd9, DW'(i + 1));
      idle(8);
      check(rd_cnt[9] == 1, "R4", "reads of skewed line", rd_cnt[9], 1);
      check(max_cnt[9] > 1, "R4", "merged completion count", max_cnt[9], 2);

      // R3 hits on resident line
      rd0 = tot_rd; wr0 = tot_wr;
      for (int i = 0; i < 3; i++) send(6'd9, 16'd10);
      idle(4);
      check(tot_rd == rd0 && tot_wr == wr0, "R3", "memory traffic on hits",
            int'(tot_rd - rd0 + tot_wr - wr0), 0);
      check(last_val[9] == golden[9], "R3", "hit value", int'(last_val[9]), int'(golden[9]));

      // R6 LRU eviction with dirty write-back
      send(6'd20, 16'd1); idle(8);
      send(6'd21, 16'd1); idle(8);
      send(6'd5, 16'd2);  idle(4);
      wr0 = tot_wr;
      send(6'd22, 16'd4); idle(8);
      check(tot_wr == wr0 + 1, "R6", "write-backs on eviction", tot_wr - wr0, 1);
      check(last_wr_addr == 6'd9, "R6", "victim line", int'(last_wr_addr), 9);
      check(rd_cnt[22] == 1, "R2", "reads of line 22", rd_cnt[22], 1);

      // R10 wrap
      send(6'd30, 16'hFFFF); idle(8);
      send(6'd30, 16'hFFFF); idle(4);
      check(last_val[30] == 16'd209, "R10", "wrapped value", int'(last_val[30]), 209);

      // skewed random traffic
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         la = (lfsr[2:0] < 3'd6) ? AW'(lfsr[4:3]) : lfsr[13:8];
         send(la, {8'd0, lfsr[15:8]});
      end

      // R8 flush
      rd0 = tot_rd; wr0 = tot_wr;
      @(negedge clk); flush_req = 1'b1;
      @(negedge clk); flush_req = 1'b0;
      idle(40);
      check(done_seen == 1, "R8", "flush_done pulses", done_seen, 1);
      check(tot_wr - wr0 <= N, "R8", "flush writes", tot_wr - wr0, N);
      bad = 0;
      for (int i = 0; i < NA; i++) if (mem[i] != golden[i]) bad++;
      check(bad == 0, "R8", "lines differing after flush", bad, 0);
      rd0 = tot_rd;
      send(la, 16'd1); idle(4);
      check(tot_rd == rd0, "R8", "reads after flush on resident line", tot_rd - rd0, 0);

      bad = 0;
      for (int i = 0; i < NA; i++) bad += expq[i].size();
      check(bad == 0, "R9", "requests never completed", bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule